// File: doc/BRIEF.md
# Frame-Modulated Pixel Intensity Generator

This block grades the brightness of multiplexed LED pixels by time. A shared counter steps through a repeating frame of twelve multiplex cycles. For every pixel, a small decoder looks at the pixel's intensity code and the current cycle index. It decides whether the pixel is lit during that cycle. Across one frame the fraction of lit cycles sets the apparent brightness.

Two grading schemes are available. Arithmetic grading gives the middle codes one third and two thirds of full brightness. Geometric grading gives them one quarter and one half. The two extreme codes are always fully dark or fully lit. When the display stores only one bit per pixel, each pixel's low code bit is stretched to a full-on or full-off code. The driving logic pulses an advance strobe once per multiplex cycle and reads one enable bit per pixel, plus the cycle index.

Top module: `fm_intensity_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets `cycle_idx` to 0, whatever `adv` is.
- R2: With `adv` high at a rising edge and no reset, `cycle_idx` goes up by one, and from 11 it returns to 0; it never leaves the range 0 to 11.
- R3: With `adv` low and no reset, `cycle_idx` keeps its value.
- R4: In two-bit mode, code 2'b11 lights the pixel in every cycle and code 2'b00 darkens it in every cycle, under both grading schemes.
- R5: Arithmetic grading (`geo_mode`=0), code 2'b10: lit in cycles 0,2,3,5,6,8,9,11 and dark in cycles 1,4,7,10.
- R6: Arithmetic grading, code 2'b01: lit only in cycles 1,4,7,10.
- R7: Geometric grading (`geo_mode`=1), code 2'b10: lit in the even cycles and dark in the odd ones.
- R8: Geometric grading, code 2'b01: lit only in cycles 1,5,9.
- R9: In one-bit mode (`two_bit`=0), bit 2i of `pix_code` alone sets pixel i: 1 lights it in every cycle and 0 darkens it in every cycle. Bit 2i+1 and `geo_mode` have no effect.
- R10: Pixel i's code occupies `pix_code[2i+1:2i]`, and `pix_on[i]` depends only on that field, the mode inputs and `cycle_idx`. The enable is combinational, so it is valid in the same cycle as the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance the multiplex cycle by one at this edge |
| geo_mode | input | 1 | 0 = arithmetic grading, 1 = geometric grading |
| two_bit | input | 1 | 1 = two-bit codes, 0 = one bit per pixel |
| pix_code | input | 2*NPIX | Intensity code of each pixel, pixel i in bits 2i+1:2i |
| pix_on | output | NPIX | Per-pixel enable for the current cycle |
| cycle_idx | output | 4 | Current multiplex cycle, 0 to 11 |

## Verification
The bench runs the block under all four combinations of grading scheme and bit width. Pixel codes are random in every cycle, so each pixel meets every code at every cycle index. This sets the one-third pattern apart from the one-quarter pattern, and the two-thirds pattern apart from the half pattern, because they differ only at certain indices. In one-bit mode the high code bit is randomised, so any leak of that bit shows up. The advance strobe is sometimes held low and a reset is pulsed in the middle of the run, so stalling, stepping, wrapping and restarting are compared cycle by cycle against a model that is built from the pattern lists.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int FRAME_LEN = 12;
  localparam int CYC_W     = $clog2(FRAME_LEN);

  typedef logic [CYC_W-1:0] cyc_t;

  typedef enum logic [1:0] {
    LVL_DARK = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_FULL = 2'b11
  } level_e;

  // Next multiplex cycle, wrapping at the end of the frame.
  function automatic cyc_t cyc_next(input cyc_t idx);
    return (idx == cyc_t'(FRAME_LEN - 1)) ? '0 : cyc_t'(idx + 1'b1);
  endfunction

  // Cycle index modulo three.
  function automatic logic [1:0] mod3(input cyc_t idx);
    return 2'(idx % 3);
  endfunction

  // Lit/dark decision for one code at one cycle.
  function automatic logic lvl_enable(input level_e lvl, input logic geo, input cyc_t idx);
    logic en;
    unique case (lvl)
      LVL_DARK: en = 1'b0;
      LVL_FULL: en = 1'b1;
      LVL_HIGH: en = geo ? ~idx[0] : (mod3(idx) != 2'd1);
      LVL_LOW:  en = geo ? (idx[1:0] == 2'b01) : (mod3(idx) == 2'd1);
      default:  en = 1'b0;
    endcase
    return en;
  endfunction
endpackage

// File: rtl/fm_cycle_ctr.sv
module fm_cycle_ctr
  import fm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output cyc_t idx
);
  logic at_last;
  logic wrap_evt;
  logic step_evt;

  assign at_last  = (idx == cyc_t'(FRAME_LEN - 1));
  assign wrap_evt = adv & at_last;
  assign step_evt = adv & ~at_last;

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= cyc_next(idx);
  end

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> idx == '0); // R1
  AST_WRAP_ZERO:  assert property (@(posedge clk) disable iff (rst) wrap_evt |=> idx == '0); // R2
  AST_STEP_UP:    assert property (@(posedge clk) disable iff (rst) step_evt |=> idx == cyc_t'($past(idx) + 1'b1)); // R2
  AST_IN_RANGE:   assert property (@(posedge clk) disable iff (rst) idx < cyc_t'(FRAME_LEN)); // R2
  AST_HOLD_IDLE:  assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(idx)); // R3
endmodule

// File: rtl/fm_pixel_gate.sv
module fm_pixel_gate
  import fm_pkg::*;
(
  input  logic [1:0] code,
  input  logic       geo,
  input  logic       two_bit,
  input  cyc_t       idx,
  output logic       on
);
  level_e lvl;

  always_comb begin
    if (two_bit) lvl = level_e'(code);
    else         lvl = code[0] ? LVL_FULL : LVL_DARK;
  end

  assign on = lvl_enable(lvl, geo, idx);
endmodule

// File: rtl/fm_intensity_gen.sv
module fm_intensity_gen
  import fm_pkg::*;
#(
  parameter int NPIX = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              geo_mode,
  input  logic              two_bit,
  input  logic [2*NPIX-1:0] pix_code,
  output logic [NPIX-1:0]   pix_on,
  output logic [CYC_W-1:0]  cycle_idx
);
  cyc_t idx;

  fm_cycle_ctr u_ctr (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .idx (idx)
  );

  assign cycle_idx = idx;

  for (genvar p = 0; p < NPIX; p++) begin : g_pix
    logic [1:0] fld;
    logic       full_code;
    logic       dark_code;
    assign fld       = pix_code[2*p +: 2];
    assign full_code = two_bit ? (fld == 2'b11) : fld[0];
    assign dark_code = two_bit ? (fld == 2'b00) : ~fld[0];

    fm_pixel_gate u_gate (
      .code    (fld),
      .geo     (geo_mode),
      .two_bit (two_bit),
      .idx     (idx),
      .on      (pix_on[p])
    );

    AST_FULL_LIT:  assert property (@(posedge clk) disable iff (rst) full_code |-> pix_on[p]); // R4
    AST_DARK_OFF:  assert property (@(posedge clk) disable iff (rst) dark_code |-> !pix_on[p]); // R4
    AST_GEO_QUART: assert property (@(posedge clk) disable iff (rst)
                     (two_bit && geo_mode && fld == 2'b01 && pix_on[p]) |-> (idx % 4 == 1)); // R8
    AST_ARI_THIRD: assert property (@(posedge clk) disable iff (rst)
                     (two_bit && !geo_mode && fld == 2'b01 && pix_on[p]) |-> (idx % 3 == 1)); // R6
  end
endmodule

// File: tb/fm_intensity_gen_tb.sv
module fm_intensity_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPIX = 8;

  logic              clk = 1'b0;
  logic              rst, adv, geo_mode, two_bit;
  logic [2*NPIX-1:0] pix_code;
  logic [NPIX-1:0]   pix_on;
  logic [3:0]        cycle_idx;

  int tests = 0;
  int fails = 0;
  int model_idx = 0;
  bit done = 0;

  int ari_hi[12]  = '{1,0,1,1,0,1,1,0,1,1,0,1};
  int ari_lo[12]  = '{0,1,0,0,1,0,0,1,0,0,1,0};
  int geo_hi[12]  = '{1,0,1,0,1,0,1,0,1,0,1,0};
  int geo_lo[12]  = '{0,1,0,0,0,1,0,0,0,1,0,0};

  fm_intensity_gen #(.NPIX(NPIX)) u_dut (
    .clk(clk), .rst(rst), .adv(adv), .geo_mode(geo_mode), .two_bit(two_bit),
    .pix_code(pix_code), .pix_on(pix_on), .cycle_idx(cycle_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int expect_on(int code, bit geo, bit wide, int c);
    if (!wide) return code % 2;
    if (code == 3) return 1;
    if (code == 0) return 0;
    if (code == 2) return geo ? geo_hi[c] : ari_hi[c];
    return geo ? geo_lo[c] : ari_lo[c];
  endfunction

  function automatic string req_tag(int code, bit geo, bit wide);
    if (!wide) return "R9";
    if (code == 3 || code == 0) return "R4";
    if (code == 2) return geo ? "R7" : "R5";
    return geo ? "R8" : "R6";
  endfunction

  task automatic check_idx(string tag);
    tests++;
    if (int'(cycle_idx) != model_idx) begin
      fails++;
      $display("FAIL %s cycle_idx actual=%0d expected=%0d", tag, cycle_idx, model_idx);
    end
  endtask

  task automatic check_pixels();
    for (int p = 0; p < NPIX; p++) begin
      int code;
      int e;
      code = int'(pix_code[2*p +: 2]);
      e = expect_on(code, geo_mode, two_bit, model_idx);
      tests++;
      // R10: each pixel judged only from its own field
      if (int'(pix_on[p]) != e) begin
        fails++;
        $display("FAIL %s/R10 pixel %0d code=%0d geo=%0b wide=%0b cyc=%0d actual=%0b expected=%0d",
                 req_tag(code, geo_mode, two_bit), p, code, geo_mode, two_bit, model_idx, pix_on[p], e);
      end
    end
  endtask

  task automatic step(bit r, bit a);
    rst = r;
    adv = a;
    @(posedge clk);
    if (r) model_idx = 0;
    else if (a) model_idx = (model_idx == 11) ? 0 : model_idx + 1;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; adv = 1'b1; geo_mode = 1'b0; two_bit = 1'b1; pix_code = '0;
    @(negedge clk);
    step(1'b1, 1'b1);
    check_idx("R1");
    for (int m = 0; m < 4; m++) begin
      geo_mode = m[0];
      two_bit  = m[1];
      for (int k = 0; k < 150; k++) begin
        bit a;
        a = ($urandom % 5) != 0;
        pix_code = 16'($urandom);
        #1;
        check_pixels();
        step(1'b0, a);
        check_idx(a ? "R2" : "R3");
        if (m == 2 && k == 70) begin
          step(1'b1, 1'b1);
          check_idx("R1");
        end
      end
    end
    // Hold off the strobe for several cycles at an arbitrary index
    for (int k = 0; k < 5; k++) begin
      step(1'b0, 1'b0);
      check_idx("R3");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule